// File: doc/BRIEF.md
# Strobe Window Calibrator

This block measures, with nothing but the system clock, how long a programmable strobe stays high or how far its rising edge lags a reference strobe. The interval is far shorter than the precision a single clock sample gives, so the block measures it statistically. Over a programmed number of asynchronous events it adds up every clock that falls inside the measurement window. The final count divided by the event count gives the mean window length in clock periods. Averaging over many events that arrive at random phases brings the resolution well below one clock period.

A single 4-bit selector code picks both the strobe channel and the kind of measurement. Software writes the selector, then writes an event count, which starts a run. It then polls a status word until the run is done and reads the accumulated count. All strobe inputs are treated as asynchronous and pass through synchronizers before use.

Top module: `strobe_cal`

## Requirements
- R1: After reset, reads of the selector (address 0), remaining events (address 1), count (address 2) and status (address 3) all return 0.
- R2: Selector codes 1 to 6 select a width measurement of tap strobes 0 to 5, and codes 9 to 14 select a delay measurement of tap strobes 0 to 5. Codes 0, 7, 8 and 15 select nothing: no clock is counted and no event is taken while they are in force.
- R3: In width mode, the count rises by one for every clock during which the selected tap strobe, after synchronization, is high. A pulse held for K clocks adds K.
- R4: In delay mode, the window opens on a rising edge of the reference strobe and closes on the next rising edge of the selected tap strobe. A tap edge D clocks after the reference edge adds D.
- R5: Each falling end of the window counts as one event and lowers the remaining-events register (address 1) by one.
- R6: Writing N to address 1 loads N events, clears the count and the saturation flag, clears done, and sets busy when N is nonzero. A write of zero sets done at once and leaves busy clear.
- R7: Status (address 3) holds done in bit 0, busy in bit 1 and saturation in bit 2. When the remaining events reach zero, done is set and busy is cleared. Later windows change neither the count nor the remaining events.
- R8: The count stops at its all-ones value instead of wrapping. A clock inside the window at that value sets the saturation flag.
- R9: Strobe activity on tap channels other than the selected one has no effect on the count or the events.
- R10: The selector written to address 0 reads back from address 0 in its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_strobe | input | 1 | Reference (undelayed) strobe, asynchronous |
| tap_strobe | input | 6 | Delayed strobe outputs under test, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |

## Verification
The bench builds the block with an 8-bit count and a 16-bit event counter, with six channels and two synchronizer stages. The narrow count brings saturation within reach after a few hundred clocks, so the stop at all-ones and the flag it raises are checked directly. Pulse and delay lengths are driven as whole clock periods, so each window adds an exact, predictable number to the count. Every invalid selector code class and a foreign channel are exercised during an open run.

// File: rtl/strobe_cal_pkg.sv
package strobe_cal_pkg;

  typedef enum logic [1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_EVT  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_STAT = 2'd3
  } cal_addr_e;

  typedef enum logic {
    KIND_WIDTH = 1'b0,
    KIND_DELAY = 1'b1
  } meas_kind_e;

  typedef struct packed {
    logic       valid;
    meas_kind_e kind;
    logic [2:0] chan;
  } sel_dec_t;

  // Low three code bits hold channel+1, the top bit picks delay over width.
  function automatic sel_dec_t decode_sel(input logic [3:0] code, input int nch);
    sel_dec_t d;
    d.chan  = code[2:0] - 3'd1;
    d.kind  = code[3] ? KIND_DELAY : KIND_WIDTH;
    d.valid = (code[2:0] != 3'd0) && (int'(code[2:0]) <= nch);
    return d;
  endfunction

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cal_window.sv
module cal_window
  import strobe_cal_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  sel_dec_t       dec,
  input  logic [NCH-1:0] tap_s,
  input  logic           ref_s,
  output logic           win,
  output logic           win_fall
);
  logic tap_sel;
  logic tap_prev_q, ref_prev_q, open_q, win_prev_q;
  logic tap_prev_d, ref_prev_d, open_d, win_prev_d;
  logic tap_rise, ref_rise;

  always_comb begin
    tap_sel = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (dec.valid && (dec.chan == 3'(i))) tap_sel = tap_s[i];
    end
  end

  assign tap_rise = tap_sel & ~tap_prev_q;
  assign ref_rise = ref_s & ~ref_prev_q;

  always_comb begin
    tap_prev_d = tap_sel;
    ref_prev_d = ref_s;
    open_d     = open_q;
    if (clr || !dec.valid || dec.kind != KIND_DELAY) open_d = 1'b0;
    else if (tap_rise)                               open_d = 1'b0;
    else if (ref_rise)                               open_d = 1'b1;
  end

  always_comb begin
    if (!dec.valid)                 win = 1'b0;
    else if (dec.kind == KIND_DELAY) win = open_q;
    else                            win = tap_sel;
  end

  assign win_prev_d = clr ? 1'b0 : win;
  assign win_fall   = win_prev_q & ~win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_prev_q <= 1'b0;
      ref_prev_q <= 1'b0;
      open_q     <= 1'b0;
      win_prev_q <= 1'b0;
    end else begin
      tap_prev_q <= tap_prev_d;
      ref_prev_q <= ref_prev_d;
      open_q     <= open_d;
      win_prev_q <= win_prev_d;
    end
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter #(
  parameter int CNT_W = 16,
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EVT_W-1:0] start_evt,
  input  logic             win,
  input  logic             win_fall,
  output logic [CNT_W-1:0] cnt,
  output logic [EVT_W-1:0] evt,
  output logic             busy,
  output logic             done,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [EVT_W-1:0] EVT_ONE = EVT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic busy_q, busy_d, done_q, done_d, sat_q, sat_d;
  logic cnt_en, evt_en;

  assign cnt_en = busy_q & win;
  assign evt_en = busy_q & win_fall;

  always_comb begin
    cnt_d  = cnt_q;
    evt_d  = evt_q;
    busy_d = busy_q;
    done_d = done_q;
    sat_d  = sat_q;
    if (start) begin
      cnt_d  = '0;
      sat_d  = 1'b0;
      evt_d  = start_evt;
      busy_d = (start_evt != '0);
      done_d = (start_evt == '0);
    end else begin
      if (cnt_en) begin
        if (cnt_q == CNT_MAX) sat_d = 1'b1;
        else                  cnt_d = cnt_q + CNT_W'(1);
      end
      if (evt_en) begin
        evt_d = evt_q - EVT_ONE;
        if (evt_q == EVT_ONE) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      evt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sat_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      evt_q  <= evt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      sat_q  <= sat_d;
    end
  end

  assign cnt  = cnt_q;
  assign evt  = evt_q;
  assign busy = busy_q;
  assign done = done_q;
  assign sat  = sat_q;
endmodule

// File: rtl/strobe_cal.sv
module strobe_cal
  import strobe_cal_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int CNT_W       = 16,
  parameter int EVT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_strobe,
  input  logic [NCH-1:0]    tap_strobe,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SYNC_W = NCH + 1;

  logic [3:0]       sel_q, sel_d;
  logic             sel_wr, start;
  sel_dec_t         dec;
  logic [SYNC_W-1:0] raw, synced;
  logic             win, win_fall;
  logic [CNT_W-1:0] cnt_w;
  logic [EVT_W-1:0] evt_w;
  logic             busy_w, done_w, sat_w;

  assign sel_wr = wr_en && (wr_addr == ADDR_SEL);
  assign start  = wr_en && (wr_addr == ADDR_EVT);
  assign sel_d  = sel_wr ? wr_data[3:0] : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign dec = decode_sel(sel_q, NCH);
  assign raw = {ref_strobe, tap_strobe};

  cal_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  cal_window #(.NCH(NCH)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(sel_wr), .dec(dec),
    .tap_s(synced[NCH-1:0]), .ref_s(synced[NCH]),
    .win(win), .win_fall(win_fall)
  );

  cal_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_evt(wr_data[EVT_W-1:0]), .win(win), .win_fall(win_fall),
    .cnt(cnt_w), .evt(evt_w), .busy(busy_w), .done(done_w), .sat(sat_w)
  );

  always_comb begin
    case (cal_addr_e'(rd_addr))
      ADDR_SEL:  rd_data = DATA_W'(sel_q);
      ADDR_EVT:  rd_data = DATA_W'(evt_w);
      ADDR_CNT:  rd_data = DATA_W'(cnt_w);
      default:   rd_data = DATA_W'({sat_w, busy_w, done_w});
    endcase
  end
endmodule

// File: rtl/strobe_cal_chk.sv
module strobe_cal_chk #(
  parameter int CNT_W = 16,
  parameter int EVT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] cnt,
  input logic [EVT_W-1:0] evt,
  input logic             busy,
  input logic             done,
  input logic             sat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !start) |=> (cnt == CMAX));

  a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cnt) && $stable(evt)));

  a_r5_evt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (evt == $past(evt) || evt == $past(evt) - EVT_W'(1)));

  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && !sat));

  a_r3_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt >= $past(cnt)));
endmodule

bind strobe_cal strobe_cal_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cnt(cnt_w), .evt(evt_w),
  .busy(busy_w), .done(done_w), .sat(sat_w)
);

// File: tb/strobe_cal_tb.sv
`timescale 1ns/1ps
module strobe_cal_tb;
  logic        clk, rst_n, ref_strobe;
  logic [5:0]  tap_strobe;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  int n_chk, n_fail;
  bit finished;

  strobe_cal #(.NCH(6), .CNT_W(8), .EVT_W(16), .SYNC_STAGES(2), .DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .tap_strobe(tap_strobe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic pulse(input int ch, input int k);
    @(negedge clk);
    tap_strobe[ch] = 1'b1;
    repeat (k) @(negedge clk);
    tap_strobe[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic delay_evt(input int ch, input int d);
    @(negedge clk);
    ref_strobe = 1'b1;
    repeat (d) @(negedge clk);
    tap_strobe[ch] = 1'b1;
    repeat (3) @(negedge clk);
    ref_strobe = 1'b0;
    tap_strobe[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset read", v, 16'd0);
    end
  endtask

  task automatic t_width();
    logic [15:0] v;
    wr(2'd0, 16'd3);            // width, tap 2
    rd(2'd0, v); chk("R10 selector readback", v, 16'd3);
    wr(2'd1, 16'd3);
    rd(2'd3, v); chk("R6 busy after start", v, 16'd2);
    pulse(2, 5);
    rd(2'd1, v); chk("R5 events after one window", v, 16'd2);
    rd(2'd2, v); chk("R3 count after 5-clock pulse", v, 16'd5);
    pulse(2, 7);
    pulse(2, 2);
    rd(2'd2, v); chk("R3 width sum", v, 16'd14);
    rd(2'd1, v); chk("R5 events exhausted", v, 16'd0);
    rd(2'd3, v); chk("R7 done status", v, 16'd1);
  endtask

  task automatic t_delay();
    logic [15:0] v;
    wr(2'd0, 16'd13);           // delay, tap 4
    wr(2'd1, 16'd2);
    delay_evt(4, 6);
    rd(2'd2, v); chk("R4 delay 6", v, 16'd6);
    delay_evt(4, 3);
    rd(2'd2, v); chk("R4 delay sum", v, 16'd9);
    rd(2'd3, v); chk("R7 done after delay run", v, 16'd1);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd2);
    pulse(0, 5);
    delay_evt(5, 4);
    rd(2'd2, v); chk("R9 other taps count", v, 16'd0);
    rd(2'd1, v); chk("R9 other taps events", v, 16'd2);
    wr(2'd0, 16'd7);
    for (int c = 0; c < 6; c++) pulse(c, 4);
    delay_evt(0, 3);
    wr(2'd0, 16'd8);
    for (int c = 0; c < 6; c++) pulse(c, 4);
    wr(2'd0, 16'd0);
    pulse(1, 4);
    wr(2'd0, 16'd15);
    delay_evt(6 - 1, 3);
    pulse(5, 3);
    rd(2'd2, v); chk("R2 invalid codes count", v, 16'd0);
    rd(2'd1, v); chk("R2 invalid codes events", v, 16'd2);
    rd(2'd3, v); chk("R2 still busy", v, 16'd2);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd1);
    pulse(0, 4);
    pulse(0, 6);
    rd(2'd2, v); chk("R7 no count after done", v, 16'd4);
    rd(2'd1, v); chk("R7 events stay zero", v, 16'd0);
  endtask

  task automatic t_sat();
    logic [15:0] v;
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd3);
    pulse(1, 100);
    pulse(1, 100);
    rd(2'd3, v); chk("R8 no sat at 200", v, 16'd2);
    pulse(1, 100);
    rd(2'd2, v); chk("R8 count held at max", v, 16'd255);
    rd(2'd3, v); chk("R8 sat and done", v, 16'd5);
    wr(2'd1, 16'd1);
    rd(2'd2, v); chk("R6 restart clears count", v, 16'd0);
    rd(2'd3, v); chk("R6 restart clears sat", v, 16'd2);
    wr(2'd1, 16'd0);
    rd(2'd3, v); chk("R6 zero write done", v, 16'd1);
    rd(2'd1, v); chk("R6 zero events", v, 16'd0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; ref_strobe = 1'b0; tap_strobe = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_width();
    t_delay();
    t_ignore();
    t_stop();
    t_sat();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule